// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block is the register-access and interrupt front end of a two-channel serial controller. A host reaches each channel through a control port and a data port. Control accesses are indirect. A control write while a channel's pointer is zero selects the register for the next access and can carry a command. The pointer then drops back to zero after that access. Baud generation and bit shifting live elsewhere. Received bytes enter as a per-channel strobe with a byte, and bytes written to the data port leave as a per-channel strobe with a byte.

The block keeps receive, transmit and break interrupt state for both channels. It presents that state as a shared modified vector, readable at register 2 of channel B, and as a pending-bits byte, readable at register 3 of channel A. One combined interrupt line is driven from both channels. Receive and transmit interrupts of a channel lock each other out of the vector while one is under service. Clearing one lets a still-pending other claim the vector.

Top module: `duoSerialIrq`

## Requirements
- R1: A control write while the channel's pointer is 0 loads the pointer from data bits 2:0. If bits 5:3 equal 001, the pointer gets 8 added (so 0x0C selects register 12 and 0x0D selects register 13). Registers 12 and 13 read back the last byte written to them.
- R2: After a control write to a non-zero register, and after any control read, that channel's pointer is 0, so the next control read returns the status register.
- R3: `irq` is the OR over both channels of three terms. The first is register 1 bit 1 set with a transmit interrupt pending. The second is register 1 bits 4:3 equal to 01 or 10 with a receive interrupt pending. The third is register 15 bit 7 set with break status set.
- R4: With the vector-high select (register 9 bit 4 of the raising channel) clear, channel B register 2 reads as follows: 0x06 for no interrupt, 0x0C for channel A receive, 0x08 for channel A transmit, 0x04 for channel B receive, and 0x00 for channel B transmit.
- R5: With that select set, the vector codes are 0x60 for no interrupt, 0x30 for channel A receive, 0x10 for channel A transmit and 0x20 for channel B receive.
- R6: Channel A register 3 reads the pending bits: 0x02 for B transmit, 0x04 for B receive, 0x10 for A transmit and 0x20 for A receive. The external bits 0x01 and 0x08 read 0. Channel B register 3 reads 0.
- R7: While a channel's receive interrupt is under service, a new transmit interrupt on that channel leaves the vector unchanged. The reverse also holds. Clearing the one under service gives the vector to the other if it is still pending.
- R8: Command 101 (bits 5:3) clears the channel's transmit interrupt. Command 111 clears the receive interrupt if it is under service, otherwise the transmit interrupt if that is under service. A clear with nothing left pending sets the vector to the no-interrupt code.
- R9: Status (register 0) is {break, 1, 0, 0, 0, 1, 0, receive-available}, which is 0x44 when idle. Register 1 reads 0x07. A data-port read returns the last accepted byte and clears both receive-available and the receive interrupt.
- R10: A data-port write raises that channel's transmit interrupt. When register 5 bit 3 is set, it also pulses `txStb` for that channel one cycle later, with the byte on `txByte`. When that bit is clear, no strobe is produced.
- R11: A received byte is accepted only when register 3 bit 0 is set and no unread byte is waiting. Other received bytes are dropped.
- R12: Writing register 9 with bits 7:6 set to 01 resets channel B, 10 resets channel A, and 11 resets both. A reset clears pending state, the enables and break status, and re-enables break interrupts. Resetting channel B also zeroes the vector. After block reset, `irq`, `txStb` and `rdData` are 0 and the vector reads 0x00.
- R13: A `brkStb` pulse sets bit 7 of that channel's status. Break status stays set until a reset of that channel.
- R14: `rdData` is loaded on the cycle after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanSel | input | 1 | Host channel select: 1 = channel A, 0 = channel B |
| isData | input | 1 | 1 = data port, 0 = control port |
| wrStb | input | 1 | Single-cycle host write strobe |
| rdStb | input | 1 | Single-cycle host read strobe (ignored if wrStb is high) |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte, registered |
| rxStb | input | 2 | Received-byte strobe per channel (bit 1 = A, bit 0 = B) |
| rxByte | input | 16 | Received bytes, [15:8] channel A, [7:0] channel B |
| brkStb | input | 2 | Break-detected pulse per channel |
| txStb | output | 2 | Transmit strobe per channel |
| txByte | output | 16 | Transmitted bytes, [15:8] channel A, [7:0] channel B |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong service flag does not show on `irq` at all. It shows only in the vector byte, on the first read of channel B register 2 after the next raise or clear. For that reason the bench reads the vector after each step of interleaved receive and transmit sequences. A pointer that fails to return to zero shows on the very next control read, which returns some other register instead of status. A wrong pending bit or enable changes `irq` within one cycle of the event, and the bench samples it at the following falling edge.

// File: rtl/duoSerialPkg.sv
package duoSerialPkg;
  localparam int NumChan = 2;
  localparam int DataW = 8;
  localparam int PtrW = 4;
  localparam int ChanB = 0;
  localparam int ChanA = 1;

  localparam logic [PtrW-1:0] RegStatus = 4'd0;
  localparam logic [PtrW-1:0] RegIntEn = 4'd1;
  localparam logic [PtrW-1:0] RegVector = 4'd2;
  localparam logic [PtrW-1:0] RegRxCtl = 4'd3;
  localparam logic [PtrW-1:0] RegTxCtl = 4'd5;
  localparam logic [PtrW-1:0] RegMaster = 4'd9;
  localparam logic [PtrW-1:0] RegBrgLo = 4'd12;
  localparam logic [PtrW-1:0] RegBrgHi = 4'd13;
  localparam logic [PtrW-1:0] RegExtEn = 4'd15;

  localparam logic [2:0] CmdHigh = 3'b001;
  localparam logic [2:0] CmdClrTx = 3'b101;
  localparam logic [2:0] CmdClrIus = 3'b111;

  localparam logic [DataW-1:0] SpecVal = 8'h07;

  typedef struct packed {
    logic ch;
    logic regWr;
    logic [PtrW-1:0] regIdx;
    logic clrTx;
    logic clrIus;
    logic ctlRd;
    logic dataRd;
    logic dataWr;
    logic [DataW-1:0] wd;
  } hostOpT;

  typedef struct packed {
    logic [NumChan-1:0] rxPend;
    logic [NumChan-1:0] txPend;
    logic [NumChan-1:0] rxSvc;
    logic [NumChan-1:0] txSvc;
    logic [DataW-1:0] vec;
  } intStateT;

  function automatic logic [DataW-1:0] vecCode(logic isRx, logic isTx, logic ch, logic hi);
    if (isRx) return (ch == 1'(ChanA)) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
    if (isTx) return (ch == 1'(ChanA)) ? (hi ? 8'h10 : 8'h08) : 8'h00;
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic intStateT raiseRx(intStateT s, logic ch, logic hi);
    intStateT r = s;
    r.rxPend[ch] = 1'b1;
    if (!r.txSvc[ch]) begin
      r.rxSvc[ch] = 1'b1;
      r.vec = vecCode(1'b1, 1'b0, ch, hi);
    end
    return r;
  endfunction

  function automatic intStateT raiseTx(intStateT s, logic ch, logic hi);
    intStateT r = s;
    r.txPend[ch] = 1'b1;
    if (!r.rxSvc[ch]) begin
      r.txSvc[ch] = 1'b1;
      r.vec = vecCode(1'b0, 1'b1, ch, hi);
    end
    return r;
  endfunction

  function automatic intStateT dropRx(intStateT s, logic ch, logic hi);
    intStateT r = s;
    r.rxPend[ch] = 1'b0;
    r.rxSvc[ch] = 1'b0;
    r.vec = vecCode(1'b0, 1'b0, ch, hi);
    if (r.txPend[ch]) r = raiseTx(r, ch, hi);
    return r;
  endfunction

  function automatic intStateT dropTx(intStateT s, logic ch, logic hi);
    intStateT r = s;
    r.txPend[ch] = 1'b0;
    r.txSvc[ch] = 1'b0;
    r.vec = vecCode(1'b0, 1'b0, ch, hi);
    if (r.rxPend[ch]) r = raiseRx(r, ch, hi);
    return r;
  endfunction
endpackage

// File: rtl/duoSerialCtrl.sv
module duoSerialCtrl
  import duoSerialPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic chanSel,
  input  logic isData,
  input  logic wrStb,
  input  logic rdStb,
  input  logic [DataW-1:0] wrData,
  output hostOpT op
);
  logic [PtrW-1:0] ptr [NumChan];
  logic [2:0] cmd;
  logic ptrWr;

  assign cmd = wrData[5:3];
  assign ptrWr = wrStb && !isData && (ptr[chanSel] == '0);

  always_comb begin
    op = '0;
    op.ch = chanSel;
    op.regIdx = ptr[chanSel];
    op.wd = wrData;
    if (wrStb && !isData) begin
      if (ptrWr) begin
        op.clrTx = (cmd == CmdClrTx);
        op.clrIus = (cmd == CmdClrIus);
      end else begin
        op.regWr = 1'b1;
      end
    end
    op.ctlRd = rdStb && !wrStb && !isData;
    op.dataRd = rdStb && !wrStb && isData;
    op.dataWr = wrStb && isData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NumChan; c++) ptr[c] <= '0;
    end else begin
      if (ptrWr) ptr[chanSel] <= {cmd == CmdHigh, wrData[2:0]};
      else if (op.regWr || op.ctlRd) ptr[chanSel] <= '0;
      if (op.regWr && op.regIdx == RegMaster) begin
        if (wrData[6]) ptr[ChanB] <= '0;
        if (wrData[7]) ptr[ChanA] <= '0;
      end
    end
  end
endmodule

// File: rtl/duoSerialDp.sv
module duoSerialDp
  import duoSerialPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  hostOpT op,
  input  logic [NumChan-1:0] rxStb,
  input  logic [NumChan*DataW-1:0] rxByte,
  input  logic [NumChan-1:0] brkStb,
  output logic [DataW-1:0] rdData,
  output logic [NumChan-1:0] txStb,
  output logic [NumChan*DataW-1:0] txByte,
  output logic irq
);
  logic [NumChan-1:0] txIntEn, rxEn, txEn, statusHi, brkEn, rxAvail, brk;
  logic [NumChan-1:0] nTxIntEn, nRxEn, nTxEn, nStatusHi, nBrkEn, nRxAvail, nBrk;
  logic [1:0] rxMode [NumChan];
  logic [1:0] nRxMode [NumChan];
  logic [DataW-1:0] brgLo [NumChan];
  logic [DataW-1:0] brgHi [NumChan];
  logic [DataW-1:0] rxData [NumChan];
  logic [DataW-1:0] nBrgLo [NumChan];
  logic [DataW-1:0] nBrgHi [NumChan];
  logic [DataW-1:0] nRxData [NumChan];
  intStateT intSt, nInt;
  logic [NumChan-1:0] resetMask;
  logic [DataW-1:0] rdNext;

  always_comb begin
    nTxIntEn = txIntEn; nRxEn = rxEn; nTxEn = txEn; nStatusHi = statusHi;
    nBrkEn = brkEn; nRxAvail = rxAvail; nBrk = brk;
    nRxMode = rxMode; nBrgLo = brgLo; nBrgHi = brgHi; nRxData = rxData;
    nInt = intSt;
    resetMask = '0;
    if (op.regWr) begin
      case (op.regIdx)
        RegIntEn: begin nTxIntEn[op.ch] = op.wd[1]; nRxMode[op.ch] = op.wd[4:3]; end
        RegRxCtl: nRxEn[op.ch] = op.wd[0];
        RegTxCtl: nTxEn[op.ch] = op.wd[3];
        RegMaster: begin
          resetMask = {op.wd[7], op.wd[6]};
          if (op.wd[7:6] == 2'b00) nStatusHi[op.ch] = op.wd[4];
        end
        RegBrgLo: nBrgLo[op.ch] = op.wd;
        RegBrgHi: nBrgHi[op.ch] = op.wd;
        RegExtEn: nBrkEn[op.ch] = op.wd[7];
        default: ;
      endcase
    end
    if (op.clrTx) nInt = dropTx(nInt, op.ch, nStatusHi[op.ch]);
    if (op.clrIus) begin
      if (nInt.rxSvc[op.ch]) nInt = dropRx(nInt, op.ch, nStatusHi[op.ch]);
      else if (nInt.txSvc[op.ch]) nInt = dropTx(nInt, op.ch, nStatusHi[op.ch]);
    end
    if (op.dataRd) begin
      nRxAvail[op.ch] = 1'b0;
      nInt = dropRx(nInt, op.ch, nStatusHi[op.ch]);
    end
    if (op.dataWr) nInt = raiseTx(nInt, op.ch, nStatusHi[op.ch]);
    for (int c = 0; c < NumChan; c++) begin
      if (resetMask[c]) begin
        nTxIntEn[c] = 1'b0; nRxEn[c] = 1'b0; nTxEn[c] = 1'b0; nStatusHi[c] = 1'b0;
        nBrkEn[c] = 1'b1; nRxAvail[c] = 1'b0; nBrk[c] = 1'b0;
        nRxMode[c] = 2'b00; nBrgLo[c] = '0; nBrgHi[c] = '0; nRxData[c] = '0;
        nInt.rxPend[c] = 1'b0; nInt.txPend[c] = 1'b0;
        nInt.rxSvc[c] = 1'b0; nInt.txSvc[c] = 1'b0;
        if (c == ChanB) nInt.vec = '0;
      end
    end
    for (int c = 0; c < NumChan; c++) begin
      if (rxStb[c] && nRxEn[c] && !nRxAvail[c]) begin
        nRxAvail[c] = 1'b1;
        nRxData[c] = rxByte[c*DataW +: DataW];
        nInt = raiseRx(nInt, 1'(c), nStatusHi[c]);
      end
      if (brkStb[c]) nBrk[c] = 1'b1;
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NumChan; c++) begin
      irq |= (txIntEn[c] && intSt.txPend[c]) ||
             ((rxMode[c] == 2'b01 || rxMode[c] == 2'b10) && intSt.rxPend[c]) ||
             (brkEn[c] && brk[c]);
    end
  end

  always_comb begin
    rdNext = '0;
    if (op.dataRd) rdNext = rxData[op.ch];
    else begin
      case (op.regIdx)
        RegStatus: rdNext = {brk[op.ch], 1'b1, 3'b000, 1'b1, 1'b0, rxAvail[op.ch]};
        RegIntEn: rdNext = SpecVal;
        RegVector: rdNext = (op.ch == 1'(ChanB)) ? intSt.vec : '0;
        4'd3: rdNext = (op.ch == 1'(ChanA)) ?
          {2'b00, intSt.rxPend[ChanA], intSt.txPend[ChanA], 1'b0,
           intSt.rxPend[ChanB], intSt.txPend[ChanB], 1'b0} : '0;
        RegBrgLo: rdNext = brgLo[op.ch];
        RegBrgHi: rdNext = brgHi[op.ch];
        default: rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIntEn <= '0; rxEn <= '0; txEn <= '0; statusHi <= '0;
      brkEn <= '1; rxAvail <= '0; brk <= '0;
      for (int c = 0; c < NumChan; c++) begin
        rxMode[c] <= 2'b00; brgLo[c] <= '0; brgHi[c] <= '0; rxData[c] <= '0;
      end
      intSt <= '0;
      rdData <= '0;
      txStb <= '0;
      txByte <= '0;
    end else begin
      txIntEn <= nTxIntEn; rxEn <= nRxEn; txEn <= nTxEn; statusHi <= nStatusHi;
      brkEn <= nBrkEn; rxAvail <= nRxAvail; brk <= nBrk;
      rxMode <= nRxMode; brgLo <= nBrgLo; brgHi <= nBrgHi; rxData <= nRxData;
      intSt <= nInt;
      if (op.dataRd || op.ctlRd) rdData <= rdNext;
      txStb <= '0;
      if (op.dataWr && txEn[op.ch]) begin
        txStb[op.ch] <= 1'b1;
        txByte[op.ch*DataW +: DataW] <= op.wd;
      end
    end
  end
endmodule

// File: rtl/duoSerialIrq.sv
module duoSerialIrq
  import duoSerialPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic chanSel,
  input  logic isData,
  input  logic wrStb,
  input  logic rdStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [1:0] rxStb,
  input  logic [15:0] rxByte,
  input  logic [1:0] brkStb,
  output logic [1:0] txStb,
  output logic [15:0] txByte,
  output logic irq
);
  hostOpT op;

  duoSerialCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .chanSel(chanSel), .isData(isData),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData), .op(op)
  );

  duoSerialDp dp_i (
    .clk(clk), .rstN(rstN), .op(op), .rxStb(rxStb), .rxByte(rxByte),
    .brkStb(brkStb), .rdData(rdData), .txStb(txStb), .txByte(txByte), .irq(irq)
  );
endmodule

// File: rtl/duoSerialChk.sv
module duoSerialChk
  import duoSerialPkg::*;
(
  input logic clk,
  input logic rstN,
  input logic chanSel,
  input logic isData,
  input logic wrStb,
  input logic rdStb,
  input logic [7:0] rdData,
  input logic [1:0] txStb,
  input hostOpT op
);
  // R10
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(txStb));

  // R10
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStb[1] |-> $past(wrStb && isData && chanSel));

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdStb) |-> $stable(rdData));

  // R2
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op.regWr || op.ctlRd) |=> ((chanSel != $past(chanSel)) || (op.regIdx == 4'd0)));
endmodule

bind duoSerialIrq duoSerialChk chk_i (.*);

// File: tb/duoSerialIrq_tb_top.sv
module duoSerialIrq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanSel = 1'b0, isData = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] rxStb = '0, brkStb = '0;
  logic [15:0] rxByte = '0;
  logic [1:0] txStb;
  logic [15:0] txByte;
  logic irq;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  duoSerialIrq dut_i (.*);

  localparam logic A = 1'b1, B = 1'b0, C = 1'b0, D = 1'b1;
  localparam logic [1:0] KWr = 2'd0, KRd = 2'd1, KRx = 2'd2;
  localparam int NSteps = 40;
  // {kind, channel, port, value, expected}
  localparam logic [19:0] steps [NSteps] = '{
    {KWr, A, C, 8'h01, 8'h00}, {KWr, A, C, 8'h12, 8'h00},
    {KWr, B, C, 8'h01, 8'h00}, {KWr, B, C, 8'h12, 8'h00},
    {KWr, A, C, 8'h03, 8'h00}, {KWr, A, C, 8'h01, 8'h00},
    {KWr, B, C, 8'h03, 8'h00}, {KWr, B, C, 8'h01, 8'h00},
    {KRd, B, C, 8'h00, 8'h44},                             // R9 idle status
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h00},  // R12 vector after reset
    {KRx, A, C, 8'h5A, 8'h00},
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h0C},  // R4 A receive
    {KWr, A, C, 8'h03, 8'h00}, {KRd, A, C, 8'h00, 8'h20},  // R6 A receive bit
    {KWr, A, D, 8'h77, 8'h00},
    {KWr, A, C, 8'h03, 8'h00}, {KRd, A, C, 8'h00, 8'h30},  // R6 both A bits
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h0C},  // R7 lockout
    {KRd, A, D, 8'h00, 8'h5A},                             // R9 data read
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h08},  // R7 transmit takes over
    {KWr, A, C, 8'h03, 8'h00}, {KRd, A, C, 8'h00, 8'h10},
    {KWr, A, C, 8'h28, 8'h00},                             // R8 clear transmit
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h06},
    {KRx, B, C, 8'h33, 8'h00},
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h04},  // R4 B receive
    {KWr, A, C, 8'h03, 8'h00}, {KRd, A, C, 8'h00, 8'h04},  // R6 B receive bit
    {KWr, B, C, 8'h38, 8'h00},                             // R8 clear in service
    {KRd, B, C, 8'h00, 8'h45},
    {KWr, B, C, 8'h02, 8'h00}, {KRd, B, C, 8'h00, 8'h06},
    {KRd, B, D, 8'h00, 8'h33},
    {KRd, B, C, 8'h00, 8'h44}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWr(input logic ch, input logic dp, input logic [7:0] v);
    @(negedge clk);
    chanSel = ch; isData = dp; wrData = v; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic hostRd(input logic ch, input logic dp, output logic [7:0] v);
    @(negedge clk);
    chanSel = ch; isData = dp; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    v = rdData;
  endtask

  task automatic regRd(input logic ch, input logic [7:0] sel, output logic [7:0] v);
    hostWr(ch, C, sel);
    hostRd(ch, C, v);
  endtask

  task automatic rxIn(input logic ch, input logic [7:0] b);
    @(negedge clk);
    rxStb[ch] = 1'b1;
    rxByte[ch*8 +: 8] = b;
    @(negedge clk);
    rxStb = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 reset irq", 16'(irq), 16'h0);
    check("R12 reset txStb", 16'(txStb), 16'h0);
    check("R12 reset rdData", 16'(rdData), 16'h0);

    for (int i = 0; i < NSteps; i++) begin
      logic [1:0] k;
      k = steps[i][19:18];
      if (k == KWr) hostWr(steps[i][17], steps[i][16], steps[i][15:8]);
      else if (k == KRx) rxIn(steps[i][17], steps[i][15:8]);
      else begin
        hostRd(steps[i][17], steps[i][16], v);
        check($sformatf("R4/R6/R7/R8/R9 table step %0d", i), 16'(v), 16'(steps[i][7:0]));
      end
    end

    // R1 / R2 pointer high bank and return
    hostWr(B, C, 8'h0C); hostWr(B, C, 8'hAB);
    hostWr(B, C, 8'h0C); hostRd(B, C, v); check("R1 reg12 readback", 16'(v), 16'hAB);
    hostRd(B, C, v); check("R2 after control read", 16'(v), 16'h44);
    hostWr(B, C, 8'h0D); hostWr(B, C, 8'h5E);
    hostRd(B, C, v); check("R2 after register write", 16'(v), 16'h44);
    hostWr(B, C, 8'h0D); hostRd(B, C, v); check("R1 reg13 readback", 16'(v), 16'h5E);

    // R5 high vector codes and R7 lockout with them
    hostWr(A, C, 8'h09); hostWr(A, C, 8'h10);
    rxIn(A, 8'h61);
    regRd(B, 8'h02, v); check("R5 A receive high", 16'(v), 16'h30);
    hostWr(A, D, 8'h42);
    regRd(B, 8'h02, v); check("R7 locked high", 16'(v), 16'h30);
    hostRd(A, D, v); check("R9 data A", 16'(v), 16'h61);
    regRd(B, 8'h02, v); check("R5 A transmit high", 16'(v), 16'h10);
    hostWr(A, C, 8'h28);
    regRd(B, 8'h02, v); check("R5 none high", 16'(v), 16'h60);
    hostWr(B, C, 8'h09); hostWr(B, C, 8'h10);
    rxIn(B, 8'h62);
    regRd(B, 8'h02, v); check("R5 B receive high", 16'(v), 16'h20);
    hostRd(B, D, v);
    check("R3 idle irq", 16'(irq), 16'h0);

    // R3 enable combinations
    rxIn(A, 8'h70);
    check("R3 rx mode 10", 16'(irq), 16'h1);
    hostWr(A, C, 8'h01); hostWr(A, C, 8'h18);
    check("R3 rx mode 11", 16'(irq), 16'h0);
    hostWr(A, C, 8'h01); hostWr(A, C, 8'h08);
    check("R3 rx mode 01", 16'(irq), 16'h1);
    hostRd(A, D, v);
    check("R3 after data read", 16'(irq), 16'h0);
    hostWr(A, D, 8'h00);
    check("R3 tx masked", 16'(irq), 16'h0);
    regRd(A, 8'h03, v); check("R6 A transmit bit", 16'(v), 16'h10);
    hostWr(A, C, 8'h01); hostWr(A, C, 8'h02);
    check("R3 tx enabled", 16'(irq), 16'h1);
    hostWr(A, C, 8'h28);
    check("R8 clear tx drops irq", 16'(irq), 16'h0);

    // R13 break
    @(negedge clk); brkStb = 2'b01; @(negedge clk); brkStb = '0;
    check("R13 break irq", 16'(irq), 16'h1);
    hostRd(B, C, v); check("R13 break status", 16'(v), 16'hC4);
    hostWr(B, C, 8'h0F); hostWr(B, C, 8'h00);
    check("R3 break disabled", 16'(irq), 16'h0);

    // R12 channel resets
    hostWr(B, C, 8'h09); hostWr(B, C, 8'h40);
    hostRd(B, C, v); check("R12 B status after reset", 16'(v), 16'h44);
    regRd(B, 8'h02, v); check("R12 vector after B reset", 16'(v), 16'h00);
    hostWr(A, D, 8'h01);
    check("R12 A tx irq before reset", 16'(irq), 16'h1);
    hostWr(B, C, 8'h09); hostWr(B, C, 8'h80);
    check("R12 irq after A reset", 16'(irq), 16'h0);
    regRd(A, 8'h03, v); check("R12 pending after A reset", 16'(v), 16'h00);
    rxIn(A, 8'h11);
    hostRd(A, C, v); check("R11 rx disabled drop", 16'(v), 16'h44);

    // R11 overrun drop
    hostWr(B, C, 8'h03); hostWr(B, C, 8'h01);
    rxIn(B, 8'h21); rxIn(B, 8'h22);
    hostRd(B, D, v); check("R11 first byte kept", 16'(v), 16'h21);
    hostRd(B, C, v); check("R9 status after read", 16'(v), 16'h44);

    // R10 transmit strobe
    hostWr(A, C, 8'h05); hostWr(A, C, 8'h08);
    hostWr(A, D, 8'h9C);
    check("R10 txStb A", 16'(txStb), 16'h2);
    check("R10 txByte A", 16'(txByte[15:8]), 16'h9C);
    @(negedge clk);
    check("R10 txStb single", 16'(txStb), 16'h0);
    hostWr(B, D, 8'h55);
    check("R10 txStb B disabled", 16'(txStb), 16'h0);
    regRd(A, 8'h03, v); check("R10 both tx pending", 16'(v), 16'h12);
    regRd(B, 8'h02, v); check("R4 B transmit", 16'(v), 16'h00);

    // R14 read data hold
    v = rdData;
    repeat (3) @(negedge clk);
    check("R14 rdData held", 16'(rdData), 16'(v));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule